// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates 64-bit virtual addresses to 48-bit physical addresses through a fully associative table. By default the table has 64 entries. Each entry covers an even/odd pair of adjacent virtual pages. Each entry has its own page size, set by a mask. The even page and the odd page each carry their own frame number, coherency code, dirty bit and valid bit.

A lookup port takes an address, the current address-space identifier and a store flag. It answers in the same cycle with a physical address, a cacheable flag and a two-bit result code.

A maintenance side holds a set of staging registers: entry high, two entry lows, page mask, index, random and wired. Privileged software reads and writes these registers through a select/data port. It then issues four commands:
- probe the table for the staged key;
- read the entry at the index into the staging registers;
- write the staged entry at the index;
- write the staged entry at the random pointer.

Random counts down through the replaceable slots every clock. Wired protects the low-numbered slots from random replacement.

Top module: `paged_tlb`

## Requirements
- R1: After a synchronous reset:
  - index reads 0 with the probe-failure flag clear;
  - random reads NUM_ENTRIES-1;
  - wired reads 0;
  - entry high, both entry lows and page mask read 0.
- R2: Register select codes are 0 entry high, 1 entry low even, 2 entry low odd, 3 page mask, 4 index, 5 random, 6 wired. Write and read-back rules:
  - Entry high keeps only bits 63:62 (region), 47:13 (VPN2) and 7:0 (ASID). Every other bit reads 0.
  - Entry lows keep only 41:0: frame 41:6, coherency 5:3, dirty 2, valid 1, global 0.
  - Page mask keeps only bits 24:13.
  - Index reads the probe-failure flag at bit 31 and the slot number in its low bits. An index write loads the slot number and clears the flag.
  - Wired keeps the low log2(NUM_ENTRIES) bits.
  - Writes to random are ignored.
- R3: Command codes are 0 idle, 1 probe, 2 read, 3 write at index, 4 write at random. A write at index stores the staged entry in the slot given by index. A read loads that slot back into the staging registers. The stored global bit is the AND of the two entry-low global bits, and a read returns it in bit 0 of both entry lows.
- R4: An entry matches a lookup only when all of the following hold:
  - its region equals address bits 63:62;
  - its VPN2 equals address bits 47:13 on every position where the mask bit is 0;
  - its ASID equals the lookup ASID, or its global bit is set.
- R5: For a contiguous mask of n ones, address bit 12+n selects the odd page (1) or the even page (0). The physical address is the selected frame number shifted left by 12, with bits 12+n-1:0 replaced by the same address bits.
- R6: lk_result encodes 0 hit, 1 miss, 2 invalid, 3 modify. The codes mean:
  - miss: no entry matches;
  - invalid: the matching page has valid 0, for loads and stores alike;
  - modify: a store to a valid matching page whose dirty bit is 0;
  - hit: any other access to a matching page.
- R7: lk_cacheable is 1 exactly when an entry matches and the selected page's coherency code is 3.
- R8: Random steps down by one each clock. In the clock after it equals wired, it returns to NUM_ENTRIES-1.
- R9: A wired write sets random to NUM_ENTRIES-1 at the same edge. With wired 0, random visits every slot.
- R10: A write at random stores the staged entry in the slot that random shows during the command cycle.
- R11: A probe loads the following into index:
  - on a match: the matching slot number, with bit 31 cleared;
  - on no match: bit 31 set, with the slot bits unchanged.
- R12: When several entries match, both lookup and probe use the lowest-numbered one.
- R13: Commands and lookups in the same cycle:
  - A lookup in the same cycle as a table write sees the old contents. The new entry takes effect from the next cycle.
  - When a command updates a staging register in the same cycle as a software write to that register, the command's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_va | input | 64 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space identifier |
| lk_store | input | 1 | 1 for a store access, 0 for a load |
| lk_pa | output | 48 | Translated physical address |
| lk_cacheable | output | 1 | Matched page is cacheable |
| lk_result | output | 2 | 0 hit, 1 miss, 2 invalid, 3 modify |
| sw_we | input | 1 | Staging register write strobe |
| sw_sel | input | 3 | Staging register select |
| sw_wdata | input | 64 | Staging register write data |
| sw_rdata | output | 64 | Selected staging register image |
| cmd | input | 3 | Maintenance command code |

## Verification
A table write and a lookup of the slot being replaced can fall in the same cycle. The bench sets up the lookup of an existing mapping in the very cycle that a write at index replaces it. The combinational answer just before the edge must still show the old frame and a hit. One cycle later, the old address must miss and the new one must translate.

A read command can also meet a software write of entry high in the same cycle. The value read back must be the table image, not the software data.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    localparam int VA_W     = 64;
    localparam int PA_W     = 48;
    localparam int ASID_W   = 8;
    localparam int PFN_W    = 36;
    localparam int VPN2_W   = 35;
    localparam int MASK_W   = 12;
    localparam int PG_SHIFT = 12;

    typedef enum logic [1:0] {
        RES_HIT     = 2'd0,
        RES_MISS    = 2'd1,
        RES_INVALID = 2'd2,
        RES_MODIFY  = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_PROBE = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WIDX  = 3'd3,
        CMD_WRND  = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        SEL_HI     = 3'd0,
        SEL_LO0    = 3'd1,
        SEL_LO1    = 3'd2,
        SEL_MASK   = 3'd3,
        SEL_INDEX  = 3'd4,
        SEL_RANDOM = 3'd5,
        SEL_WIRED  = 3'd6
    } sel_e;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic [2:0]       coh;
        logic             dirty;
        logic             valid;
    } half_t;

    typedef struct packed {
        logic [1:0]        region;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
    } key_t;

    typedef struct packed {
        logic [1:0]        region;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic [MASK_W-1:0] mask;
        logic              glob;
        half_t             even;
        half_t             odd;
    } entry_t;

    // Compare one entry against a search key; mask bits widen the page.
    function automatic logic key_match(entry_t e, key_t k);
        logic [VPN2_W-1:0] care;
        care = ~{{(VPN2_W-MASK_W){1'b0}}, e.mask};
        return (e.region == k.region)
            && (((e.vpn2 ^ k.vpn2) & care) == '0)
            && (e.glob || (e.asid == k.asid));
    endfunction

    function automatic logic [3:0] mask_ones(logic [MASK_W-1:0] m);
        logic [3:0] n;
        n = '0;
        for (int b = 0; b < MASK_W; b++) n = n + {3'b0, m[b]};
        return n;
    endfunction

    function automatic logic [63:0] lo_image(half_t h, logic g);
        return {22'b0, h.pfn, h.coh, h.dirty, h.valid, g};
    endfunction

endpackage

// File: rtl/ptlb_cam.sv
module ptlb_cam
    import ptlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 64,
    localparam int IW          = $clog2(NUM_ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  entry_t        wr_entry,
    input  logic [IW-1:0] rd_idx,
    output entry_t        rd_entry,
    input  key_t          lk_key,
    output logic          lk_hit,
    output entry_t        lk_entry,
    input  key_t          pr_key,
    output logic          pr_hit,
    output logic [IW-1:0] pr_idx
);

    entry_t                 ents [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] lk_vec;
    logic [NUM_ENTRIES-1:0] pr_vec;
    logic [IW-1:0]          lk_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ents[i] <= '0;
        end else if (wr_en) begin
            ents[wr_idx] <= wr_entry;
        end
    end

    // One comparator pair per slot.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        assign lk_vec[g] = key_match(ents[g], lk_key);
        assign pr_vec[g] = key_match(ents[g], pr_key);
    end

    // Lowest slot number wins (R12).
    always_comb begin
        lk_hit = 1'b0;
        lk_idx = '0;
        pr_hit = 1'b0;
        pr_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (lk_vec[i]) begin
                lk_hit = 1'b1;
                lk_idx = IW'(i);
            end
            if (pr_vec[i]) begin
                pr_hit = 1'b1;
                pr_idx = IW'(i);
            end
        end
    end

    assign lk_entry = ents[lk_idx];
    assign rd_entry = ents[rd_idx];

    // R3 / R13: a written slot holds the staged image from the next cycle.
    a_r3_slot_written: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ents[$past(wr_idx)] == $past(wr_entry)));

endmodule

// File: rtl/ptlb_xlate.sv
module ptlb_xlate
    import ptlb_pkg::*;
(
    input  logic              hit,
    input  logic [MASK_W-1:0] mask,
    input  half_t             even,
    input  half_t             odd,
    input  logic [PA_W-1:0]   va,
    input  logic              store,
    output logic [PA_W-1:0]   pa,
    output logic              cacheable,
    output logic [1:0]        result
);

    logic [5:0]      sh;
    logic [PA_W-1:0] offm;
    logic            pick_odd;
    half_t           pg;
    res_e            res;

    always_comb begin
        sh        = 6'(PG_SHIFT) + {2'b0, mask_ones(mask)};
        offm      = (PA_W'(1) << sh) - PA_W'(1);
        pick_odd  = va[sh];
        pg        = pick_odd ? odd : even;
        pa        = ({pg.pfn, {PG_SHIFT{1'b0}}} & ~offm) | (va & offm);
        cacheable = hit && (pg.coh == 3'd3);
        if (!hit)                        res = RES_MISS;
        else if (!pg.valid)              res = RES_INVALID;
        else if (store && !pg.dirty)     res = RES_MODIFY;
        else                             res = RES_HIT;
        result = res;
    end

endmodule

// File: rtl/ptlb_regs.sv
module ptlb_regs
    import ptlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 64,
    localparam int IW          = $clog2(NUM_ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_we,
    input  logic [2:0]    sw_sel,
    input  logic [63:0]   sw_wdata,
    output logic [63:0]   sw_rdata,
    input  logic [2:0]    cmd,
    input  logic          pr_hit,
    input  logic [IW-1:0] pr_idx,
    input  entry_t        rd_entry,
    output entry_t        stage_entry,
    output key_t          stage_key,
    output logic [IW-1:0] idx,
    output logic [IW-1:0] rnd
);

    localparam logic [IW-1:0] LAST = IW'(NUM_ENTRIES - 1);

    logic [1:0]        hi_region;
    logic [VPN2_W-1:0] hi_vpn2;
    logic [ASID_W-1:0] hi_asid;
    half_t             lo0, lo1;
    logic              g0, g1;
    logic [MASK_W-1:0] pmask;
    logic              idx_p;
    logic [IW-1:0]     wired;
    logic              wired_we;
    cmd_e              op;
    sel_e              sel;

    assign op       = cmd_e'(cmd);
    assign sel      = sel_e'(sw_sel);
    assign wired_we = sw_we && (sel == SEL_WIRED);

    logic unused_wdata;
    assign unused_wdata = ^{sw_wdata[61:48], sw_wdata[12:8]};

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_region <= '0;
            hi_vpn2   <= '0;
            hi_asid   <= '0;
            lo0       <= '0;
            lo1       <= '0;
            g0        <= 1'b0;
            g1        <= 1'b0;
            pmask     <= '0;
            idx       <= '0;
            idx_p     <= 1'b0;
            wired     <= '0;
            rnd       <= LAST;
        end else begin
            if (sw_we) begin
                case (sel)
                    SEL_HI: begin
                        hi_region <= sw_wdata[63:62];
                        hi_vpn2   <= sw_wdata[47:13];
                        hi_asid   <= sw_wdata[7:0];
                    end
                    SEL_LO0: begin
                        lo0 <= '{pfn: sw_wdata[41:6], coh: sw_wdata[5:3],
                                 dirty: sw_wdata[2], valid: sw_wdata[1]};
                        g0  <= sw_wdata[0];
                    end
                    SEL_LO1: begin
                        lo1 <= '{pfn: sw_wdata[41:6], coh: sw_wdata[5:3],
                                 dirty: sw_wdata[2], valid: sw_wdata[1]};
                        g1  <= sw_wdata[0];
                    end
                    SEL_MASK:  pmask <= sw_wdata[24:13];
                    SEL_INDEX: begin
                        idx   <= sw_wdata[IW-1:0];
                        idx_p <= 1'b0;
                    end
                    SEL_WIRED: wired <= sw_wdata[IW-1:0];
                    default: ;
                endcase
            end

            // Replacement pointer.
            if (wired_we || (rnd == wired)) rnd <= LAST;
            else                            rnd <= rnd - 1'b1;

            // Command updates come last so they win over software writes.
            case (op)
                CMD_PROBE: begin
                    if (pr_hit) begin
                        idx   <= pr_idx;
                        idx_p <= 1'b0;
                    end else begin
                        idx_p <= 1'b1;
                    end
                end
                CMD_READ: begin
                    hi_region <= rd_entry.region;
                    hi_vpn2   <= rd_entry.vpn2;
                    hi_asid   <= rd_entry.asid;
                    pmask     <= rd_entry.mask;
                    lo0       <= rd_entry.even;
                    lo1       <= rd_entry.odd;
                    g0        <= rd_entry.glob;
                    g1        <= rd_entry.glob;
                end
                default: ;
            endcase
        end
    end

    assign stage_key   = '{region: hi_region, vpn2: hi_vpn2, asid: hi_asid};
    assign stage_entry = '{region: hi_region, vpn2: hi_vpn2, asid: hi_asid,
                           mask: pmask, glob: g0 & g1, even: lo0, odd: lo1};

    always_comb begin
        case (sel)
            SEL_HI:     sw_rdata = {hi_region, 14'b0, hi_vpn2, 5'b0, hi_asid};
            SEL_LO0:    sw_rdata = lo_image(lo0, g0);
            SEL_LO1:    sw_rdata = lo_image(lo1, g1);
            SEL_MASK:   sw_rdata = {39'b0, pmask, 13'b0};
            SEL_INDEX:  sw_rdata = {32'b0, idx_p, {(31-IW){1'b0}}, idx};
            SEL_RANDOM: sw_rdata = {{(64-IW){1'b0}}, rnd};
            SEL_WIRED:  sw_rdata = {{(64-IW){1'b0}}, wired};
            default:    sw_rdata = '0;
        endcase
    end

    a_r8_random_floor: assert property (@(posedge clk) disable iff (rst)
        rnd >= wired);

    a_r8_random_step: assert property (@(posedge clk) disable iff (rst)
        (!wired_we && (rnd != wired)) |=> (rnd == $past(rnd) - 1'b1));

    a_r9_wired_reload: assert property (@(posedge clk) disable iff (rst)
        wired_we |=> (rnd == LAST));

    a_r11_probe_miss: assert property (@(posedge clk) disable iff (rst)
        ((op == CMD_PROBE) && !pr_hit) |=> idx_p);

    a_r11_probe_hit: assert property (@(posedge clk) disable iff (rst)
        ((op == CMD_PROBE) && pr_hit) |=> (!idx_p && (idx == $past(pr_idx))));

endmodule

// File: rtl/paged_tlb.sv
module paged_tlb
    import ptlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] lk_va,
    input  logic [7:0]  lk_asid,
    input  logic        lk_store,
    output logic [47:0] lk_pa,
    output logic        lk_cacheable,
    output logic [1:0]  lk_result,
    input  logic        sw_we,
    input  logic [2:0]  sw_sel,
    input  logic [63:0] sw_wdata,
    output logic [63:0] sw_rdata,
    input  logic [2:0]  cmd
);

    localparam int IW = $clog2(NUM_ENTRIES);

    entry_t        stage_entry;
    entry_t        rd_entry;
    entry_t        lk_entry;
    key_t          stage_key;
    key_t          lk_key;
    logic          lk_hit;
    logic          pr_hit;
    logic [IW-1:0] pr_idx;
    logic [IW-1:0] idx;
    logic [IW-1:0] rnd;
    logic          tbl_we;
    logic [IW-1:0] tbl_widx;

    logic unused_va;
    assign unused_va = ^lk_va[61:48];

    assign lk_key   = '{region: lk_va[63:62], vpn2: lk_va[47:13], asid: lk_asid};
    assign tbl_we   = (cmd == CMD_WIDX) || (cmd == CMD_WRND);
    assign tbl_widx = (cmd == CMD_WRND) ? rnd : idx;

    ptlb_regs #(.NUM_ENTRIES(NUM_ENTRIES)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .sw_we       (sw_we),
        .sw_sel      (sw_sel),
        .sw_wdata    (sw_wdata),
        .sw_rdata    (sw_rdata),
        .cmd         (cmd),
        .pr_hit      (pr_hit),
        .pr_idx      (pr_idx),
        .rd_entry    (rd_entry),
        .stage_entry (stage_entry),
        .stage_key   (stage_key),
        .idx         (idx),
        .rnd         (rnd)
    );

    ptlb_cam #(.NUM_ENTRIES(NUM_ENTRIES)) u_cam (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_widx),
        .wr_entry (stage_entry),
        .rd_idx   (idx),
        .rd_entry (rd_entry),
        .lk_key   (lk_key),
        .lk_hit   (lk_hit),
        .lk_entry (lk_entry),
        .pr_key   (stage_key),
        .pr_hit   (pr_hit),
        .pr_idx   (pr_idx)
    );

    ptlb_xlate u_xlate (
        .hit       (lk_hit),
        .mask      (lk_entry.mask),
        .even      (lk_entry.even),
        .odd       (lk_entry.odd),
        .va        (lk_va[47:0]),
        .store     (lk_store),
        .pa        (lk_pa),
        .cacheable (lk_cacheable),
        .result    (lk_result)
    );

    logic unused_lk;
    assign unused_lk = ^{lk_entry.region, lk_entry.vpn2, lk_entry.asid, lk_entry.glob};

endmodule

// File: tb/sim_paged_tlb.sv
module sim_paged_tlb;

    localparam int CLK_PERIOD = 10;
    localparam int NE         = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_store = 1'b0;
    logic [47:0] lk_pa;
    logic        lk_cacheable;
    logic [1:0]  lk_result;
    logic        sw_we = 1'b0;
    logic [2:0]  sw_sel = '0;
    logic [63:0] sw_wdata = '0;
    logic [63:0] sw_rdata;
    logic [2:0]  cmd = '0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    paged_tlb #(.NUM_ENTRIES(NE)) u0 (
        .clk(clk), .rst(rst), .lk_va(lk_va), .lk_asid(lk_asid), .lk_store(lk_store),
        .lk_pa(lk_pa), .lk_cacheable(lk_cacheable), .lk_result(lk_result),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .cmd(cmd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] s, input logic [63:0] d);
        sw_we = 1'b1; sw_sel = s; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] s, output logic [63:0] d);
        sw_sel = s;
        #1;
        d = sw_rdata;
    endtask

    task automatic run(input logic [2:0] c);
        cmd = c;
        @(negedge clk);
        cmd = 3'd0;
    endtask

    task automatic look(input logic [63:0] va, input logic [7:0] a, input logic st);
        lk_va = va; lk_asid = a; lk_store = st;
        #1;
    endtask

    // Table contents used by the sweeps.
    function automatic int kk(int i);           return (i % 4) * 2; endfunction
    function automatic logic [63:0] reg_of(int i); return (i % 3 == 2) ? 64'd3 : 64'(i % 3); endfunction
    function automatic logic [63:0] vpn_of(int i); return 64'(i + 1) << 12; endfunction
    function automatic logic [63:0] pfn_of(int i, int p); return 64'(i * 4 + 1 + p) << 8; endfunction
    function automatic logic [63:0] coh_of(int i, int p);
        if (p == 0) return (i % 2 == 0) ? 64'd3 : 64'd2;
        return (i % 3 == 0) ? 64'd3 : 64'd7;
    endfunction
    function automatic logic [63:0] dty_of(int i, int p); return (p == 0) ? 64'd1 : 64'(i % 2); endfunction
    function automatic logic [63:0] vld_of(int i, int p); return (p == 1 && i == 3) ? 64'd0 : 64'd1; endfunction
    function automatic logic [63:0] gl_of(int i, int p);
        if (p == 0) return ((i % 2 == 0) || (i % 4 == 1)) ? 64'd1 : 64'd0;
        return (i % 2 == 0) ? 64'd1 : 64'd0;
    endfunction
    function automatic logic [63:0] hi_img(int i);
        return (reg_of(i) << 62) | (vpn_of(i) << 13) | 64'(16 + i);
    endfunction
    function automatic logic [63:0] lo_img(int i, int p, logic [63:0] g);
        return (pfn_of(i, p) << 6) | (coh_of(i, p) << 3) | (dty_of(i, p) << 2)
             | (vld_of(i, p) << 1) | g;
    endfunction
    function automatic logic [63:0] va_of(int i, int p);
        logic [63:0] v;
        int k;
        k = kk(i);
        v = (reg_of(i) << 62) | (vpn_of(i) << 13) | 64'h0ABC;
        if (k > 0) v = v | (64'd1 << (11 + k));
        if (p != 0) v = v | (64'd1 << (12 + k));
        return v;
    endfunction
    function automatic logic [63:0] pa_of(int i, int p);
        logic [63:0] offm;
        offm = (64'd1 << (12 + kk(i))) - 64'd1;
        return (((pfn_of(i, p) << 12) & ~offm) | (va_of(i, p) & offm)) & 64'hFFFF_FFFF_FFFF;
    endfunction

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [63:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rreg(3'd5, d); check("R1", "random", d, 64'(NE - 1));
        rreg(3'd4, d); check("R1", "index", d, 64'd0);
        rreg(3'd6, d); check("R1", "wired", d, 64'd0);
        rreg(3'd0, d); check("R1", "entry high", d, 64'd0);
        rreg(3'd1, d); check("R1", "entry low even", d, 64'd0);
        @(negedge clk);

        // R2 writable fields
        wreg(3'd0, '1); rreg(3'd0, d);
        check("R2", "entry high mask", d, (64'd3 << 62) | (((64'd1 << 35) - 1) << 13) | 64'hFF);
        wreg(3'd2, '1); rreg(3'd2, d);
        check("R2", "entry low mask", d, (64'd1 << 42) - 1);
        wreg(3'd3, '1); rreg(3'd3, d);
        check("R2", "page mask", d, 64'hFFF << 13);
        wreg(3'd4, '1); rreg(3'd4, d);
        check("R2", "index write", d, 64'(NE - 1));
        wreg(3'd6, '1); rreg(3'd6, d);
        check("R2", "wired write", d, 64'(NE - 1));
        wreg(3'd5, 64'd0); rreg(3'd5, d);
        check("R2", "random write ignored", d, 64'(NE - 1));
        wreg(3'd6, 64'd0);

        // R3 program every slot by index, with junk in ignored fields
        for (int i = 0; i < NE; i++) begin
            wreg(3'd0, hi_img(i) | (64'h3FFF << 48) | (64'h1F << 8));
            wreg(3'd1, lo_img(i, 0, gl_of(i, 0)) | (64'd1 << 63));
            wreg(3'd2, lo_img(i, 1, gl_of(i, 1)));
            wreg(3'd3, (((64'd1 << kk(i)) - 1) << 13) | (64'd1 << 30));
            wreg(3'd4, 64'(i));
            run(3'd3);
        end
        wreg(3'd0, 64'd0);
        for (int i = 0; i < NE; i++) begin
            logic [63:0] g;
            g = gl_of(i, 0) & gl_of(i, 1);
            wreg(3'd4, 64'(i));
            run(3'd2);
            rreg(3'd0, d); check("R3", $sformatf("read high slot %0d", i), d, hi_img(i));
            rreg(3'd1, d); check("R3", $sformatf("read even slot %0d", i), d, lo_img(i, 0, g));
            rreg(3'd2, d); check("R3", $sformatf("read odd slot %0d", i), d, lo_img(i, 1, g));
            rreg(3'd3, d); check("R3", $sformatf("read mask slot %0d", i), d, ((64'd1 << kk(i)) - 1) << 13);
        end

        // R4..R7 sweep every slot, both pages, load and store
        for (int i = 0; i < NE; i++) begin
            for (int p = 0; p < 2; p++) begin
                for (int st = 0; st < 2; st++) begin
                    logic [63:0] eres;
                    if (vld_of(i, p) == 0)                  eres = 64'd2;
                    else if (st == 1 && dty_of(i, p) == 0)  eres = 64'd3;
                    else                                    eres = 64'd0;
                    look(va_of(i, p), 8'(16 + i), st[0]);
                    check("R6", $sformatf("result slot %0d page %0d st %0d", i, p, st),
                          64'(lk_result), eres);
                    check("R5", $sformatf("pa slot %0d page %0d", i, p), 64'(lk_pa), pa_of(i, p));
                    check("R7", $sformatf("cacheable slot %0d page %0d", i, p),
                          64'(lk_cacheable), (coh_of(i, p) == 3) ? 64'd1 : 64'd0);
                end
            end
        end

        // R4 ASID, region and VPN2 checks
        for (int i = 0; i < NE; i++) begin
            look(va_of(i, 0), 8'd99, 1'b0);
            check("R4", $sformatf("foreign asid slot %0d", i), 64'(lk_result),
                  (i % 2 == 0) ? 64'd0 : 64'd1);
            look(va_of(i, 0) ^ (64'd1 << (13 + kk(i))), 8'(16 + i), 1'b0);
            check("R4", $sformatf("vpn bit above page slot %0d", i), 64'(lk_result), 64'd1);
        end
        look((va_of(0, 0) & ~(64'd3 << 62)) | (64'd2 << 62), 8'd16, 1'b0);
        check("R4", "region 2 miss", 64'(lk_result), 64'd1);
        check("R7", "miss not cacheable", 64'(lk_cacheable), 64'd0);

        // R11 probe
        wreg(3'd0, hi_img(5)); run(3'd1); rreg(3'd4, d);
        check("R11", "probe hit slot 5", d, 64'd5);
        wreg(3'd0, (hi_img(5) & ~64'hFF) | 64'd99); run(3'd1); rreg(3'd4, d);
        check("R11", "probe miss keeps index", d, (64'd1 << 31) | 64'd5);
        wreg(3'd0, (hi_img(4) & ~64'hFF) | 64'd99); run(3'd1); rreg(3'd4, d);
        check("R11", "probe global slot 4", d, 64'd4);

        // R13 lookup in the same cycle as a table write of that slot
        wreg(3'd0, (64'd1 << 32) << 13 | 64'd7);
        wreg(3'd1, (64'h77700 << 6) | (64'd3 << 3) | 64'd6);
        wreg(3'd2, 64'd0);
        wreg(3'd3, 64'd0);
        wreg(3'd4, 64'd2);
        lk_va = va_of(2, 0); lk_asid = 8'd18; lk_store = 1'b0;
        cmd = 3'd3;
        #1;
        check("R13", "old result in write cycle", 64'(lk_result), 64'd0);
        check("R13", "old pa in write cycle", 64'(lk_pa), pa_of(2, 0));
        @(negedge clk);
        cmd = 3'd0;
        #1;
        check("R13", "old mapping gone", 64'(lk_result), 64'd1);
        look(((64'd1 << 32) << 13) | 64'h123, 8'd7, 1'b1);
        check("R13", "new mapping result", 64'(lk_result), 64'd0);
        check("R13", "new mapping pa", 64'(lk_pa), (64'h77700 << 12) | 64'h123);
        // command beats software write of the same register
        wreg(3'd4, 64'd0);
        cmd = 3'd2; sw_we = 1'b1; sw_sel = 3'd0; sw_wdata = 64'hDEAD;
        @(negedge clk);
        cmd = 3'd0; sw_we = 1'b0;
        rreg(3'd0, d); check("R13", "read wins over write", d, hi_img(0));

        // R12 overlapping slots 1 and 6
        for (int s = 0; s < 2; s++) begin
            wreg(3'd0, ((64'd1 << 34) << 13) | 64'd5);
            wreg(3'd1, ((s == 0 ? 64'h11100 : 64'h22200) << 6) | (64'd2 << 3) | 64'd6);
            wreg(3'd2, 64'd0);
            wreg(3'd4, (s == 0) ? 64'd6 : 64'd1);
            run(3'd3);
        end
        look(((64'd1 << 34) << 13) | 64'h456, 8'd5, 1'b0);
        check("R12", "lowest slot lookup", 64'(lk_pa), (64'h22200 << 12) | 64'h456);
        run(3'd1); rreg(3'd4, d);
        check("R12", "lowest slot probe", d, 64'd1);

        // R8 random with wired 5
        wreg(3'd6, 64'd5);
        for (int j = 0; j < 7; j++) begin
            rreg(3'd5, d);
            check("R8", $sformatf("random step %0d", j), d, 64'(7 - (j % 3)));
            @(negedge clk);
        end
        // R9 wired 0 covers all slots
        wreg(3'd6, 64'd0);
        for (int j = 0; j < 10; j++) begin
            rreg(3'd5, d);
            check("R9", $sformatf("random full %0d", j), d, 64'(7 - (j % 8)));
            @(negedge clk);
        end

        // R10 write at random
        wreg(3'd0, ((64'd1 << 33) << 13) | 64'd9);
        wreg(3'd1, (64'h33300 << 6) | (64'd3 << 3) | 64'd6);
        sw_sel = 3'd5; cmd = 3'd4;
        #1;
        r = sw_rdata;
        @(negedge clk);
        cmd = 3'd0;
        wreg(3'd0, 64'd0);
        wreg(3'd4, r);
        run(3'd2);
        rreg(3'd0, d);
        check("R10", $sformatf("slot %0d from random", r), d, ((64'd1 << 33) << 13) | 64'd9);
        look(((64'd1 << 33) << 13) | 64'h789, 8'd9, 1'b0);
        check("R10", "random-written mapping", 64'(lk_pa), (64'h33300 << 12) | 64'h789);

        // R9 write at random respects wired
        wreg(3'd6, 64'd6);
        @(negedge clk);
        sw_sel = 3'd5;
        #1;
        check("R9", "random above wired", 64'(sw_rdata >= 64'd6), 64'd1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule